// File: doc/BRIEF.md
# PHY Reset and Readiness Sequencer

This block owns the active-low reset line of an external Ethernet PHY and decides when the PHY may be reached over its management bus. A power-on reset of the block, or a one-cycle software start pulse, drives the line low for a minimum assert time. The block then releases the line and counts a boot wait before it raises a ready flag. The wait after power-on is the long cold wait. The wait after a software-triggered reset of an already powered PHY is the shorter warm wait. All durations are given in microseconds and converted to cycles from the clock frequency parameter.

Management requests come in on a valid/ready handshake. While the PHY is ready they pass straight through to the downstream management controller. While it is not ready they are accepted at once, are not passed on, and get a one-cycle not-ready error pulse. An early request therefore always completes and never blocks its requester.

Top module: `phy_reset_seq`

## Requirements
- R1: While `rst` is high, `phy_rst_n_o` is 0, `ready_o` is 0, `fwd_valid_o` is 0 and `rsp_err_o` is 0.
- R2: After `rst` falls, `phy_rst_n_o` stays 0 for the first A sampled cycles and is 1 from cycle A+1 on. A is ASSERT_US converted to cycles, and cycles are counted from the first rising edge that sees `rst` low.
- R3: After power-on, `ready_o` rises in cycle A+Wc+1, where Wc is the cold wait COLD_US in cycles. `ready_o` is never 1 while `phy_rst_n_o` is 0.
- R4: A one-cycle `start_i` pulse drives `phy_rst_n_o` low from the next cycle. The line stays low for exactly A cycles and then returns high.
- R5: After a `start_i` pulse, `ready_o` rises in cycle A+Ww+1, where Ww is the warm wait WARM_US in cycles. The cold wait applies again only after a new `rst`.
- R6: A `start_i` pulse in any state, including mid boot wait and ready, restarts the sequence from the reset phase. `ready_o` is 0 in the next cycle and the full timing of R4 and R5 runs from that pulse.
- R7: While `ready_o` is 0, a request with `req_valid_i` high sees `req_ready_o` high in the same cycle and is not forwarded (`fwd_valid_o` stays 0). `rsp_err_o` is high for exactly one cycle, the cycle after acceptance, for each such request.
- R8: While `ready_o` is 1, a request is forwarded with `fwd_valid_o` high and `fwd_cmd_o` equal to `req_cmd_i`. `req_ready_o` follows `fwd_ready_i`, and `rsp_err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high power-on reset |
| start_i | input | 1 | Software reset request pulse |
| phy_rst_n_o | output | 1 | Registered active-low PHY reset line |
| ready_o | output | 1 | PHY may be accessed |
| req_valid_i | input | 1 | Management request valid |
| req_cmd_i | input | CMD_W | Management request payload |
| req_ready_o | output | 1 | Request accepted this cycle |
| fwd_valid_o | output | 1 | Request forwarded to the management controller |
| fwd_cmd_o | output | CMD_W | Forwarded payload |
| fwd_ready_i | input | 1 | Management controller accepts |
| rsp_err_o | output | 1 | One-cycle not-ready error for an early request |

## Verification
The bench measures the exact cycle in which the reset line and the ready flag change after power-on, after a warm start, after a restart in the middle of the boot wait and after a restart from ready. An off-by-one counter, a sequencer that kept the cold wait after a warm start, or one that ignored a restart mid-wait would shift these edges and be caught. Early requests are sent back to back and must each complete at once with their own error pulse, never reach the controller. A gate that stalled or leaked them would leave a scoreboard entry unmatched or show a stray forward. Backpressure while ready is also checked, because a design that always accepted would drop commands.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ASSERT = 2'd1,
    ST_BOOT   = 2'd2,
    ST_READY  = 2'd3
  } seq_state_e;

  // Convert a microsecond duration to clock cycles, never below one cycle.
  function automatic int unsigned us_to_cyc(input longint unsigned clk_hz,
                                            input longint unsigned dur_us);
    longint unsigned c;
    c = (clk_hz * dur_us) / 64'd1_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (en_i)      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == last_i);
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       done_i,
  output seq_state_e state_o,
  output logic       cold_o,
  output logic       clear_o,
  output logic       pin_o,
  output logic       ready_o
);
  seq_state_e state_q, state_d;
  logic       cold_q, cold_d;
  logic       pin_q, ready_q;

  always_comb begin
    state_d = state_q;
    cold_d  = cold_q;
    clear_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        state_d = ST_ASSERT;
        clear_o = 1'b1;
      end
      ST_ASSERT: if (done_i) begin
        state_d = ST_BOOT;
        clear_o = 1'b1;
      end
      ST_BOOT: if (done_i) begin
        state_d = ST_READY;
        clear_o = 1'b1;
      end
      default: ;
    endcase
    if (start_i) begin
      state_d = ST_ASSERT;
      cold_d  = 1'b0;
      clear_o = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cold_q  <= 1'b1;
      pin_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cold_q  <= cold_d;
      pin_q   <= (state_d == ST_BOOT) || (state_d == ST_READY);
      ready_q <= (state_d == ST_READY);
    end
  end

  assign state_o = state_q;
  assign cold_o  = cold_q;
  assign pin_o   = pin_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/phy_seq_gate.sv
module phy_seq_gate #(
  parameter int unsigned CMD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready_i,
  input  logic             req_valid_i,
  input  logic [CMD_W-1:0] req_cmd_i,
  output logic             req_ready_o,
  output logic             fwd_valid_o,
  output logic [CMD_W-1:0] fwd_cmd_o,
  input  logic             fwd_ready_i,
  output logic             rsp_err_o
);
  logic err_q;

  assign fwd_valid_o = req_valid_i && ready_i;
  assign fwd_cmd_o   = req_cmd_i;
  assign req_ready_o = ready_i ? fwd_ready_i : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= req_valid_i && !ready_i;
  end

  assign rsp_err_o = err_q;
endmodule

// File: rtl/phy_reset_seq.sv
module phy_reset_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned ASSERT_US = 25,
  parameter int unsigned COLD_US   = 50_000,
  parameter int unsigned WARM_US   = 3_000,
  parameter int unsigned CMD_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             phy_rst_n_o,
  output logic             ready_o,
  input  logic             req_valid_i,
  input  logic [CMD_W-1:0] req_cmd_i,
  output logic             req_ready_o,
  output logic             fwd_valid_o,
  output logic [CMD_W-1:0] fwd_cmd_o,
  input  logic             fwd_ready_i,
  output logic             rsp_err_o
);
  localparam int unsigned ASSERT_CYC = us_to_cyc(CLK_HZ, ASSERT_US);
  localparam int unsigned COLD_CYC   = us_to_cyc(CLK_HZ, COLD_US);
  localparam int unsigned WARM_CYC   = us_to_cyc(CLK_HZ, WARM_US);
  localparam int unsigned BOOT_MAX   = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
  localparam int unsigned MAX_CYC    = (BOOT_MAX > ASSERT_CYC) ? BOOT_MAX : ASSERT_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LAST_ASSERT = CNT_W'(ASSERT_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_COLD   = CNT_W'(COLD_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_WARM   = CNT_W'(WARM_CYC - 1);

  seq_state_e       state;
  logic             cold, clear, done, ready;
  logic             timing_en;
  logic [CNT_W-1:0] last_sel;

  assign timing_en = (state == ST_ASSERT) || (state == ST_BOOT);

  always_comb begin
    if (state == ST_ASSERT) last_sel = LAST_ASSERT;
    else if (cold)          last_sel = LAST_COLD;
    else                    last_sel = LAST_WARM;
  end

  phy_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear_i (clear),
    .en_i    (timing_en),
    .last_i  (last_sel),
    .done_o  (done)
  );

  phy_seq_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .done_i  (done),
    .state_o (state),
    .cold_o  (cold),
    .clear_o (clear),
    .pin_o   (phy_rst_n_o),
    .ready_o (ready)
  );

  phy_seq_gate #(.CMD_W(CMD_W)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .ready_i     (ready),
    .req_valid_i (req_valid_i),
    .req_cmd_i   (req_cmd_i),
    .req_ready_o (req_ready_o),
    .fwd_valid_o (fwd_valid_o),
    .fwd_cmd_o   (fwd_cmd_o),
    .fwd_ready_i (fwd_ready_i),
    .rsp_err_o   (rsp_err_o)
  );

  assign ready_o = ready;
endmodule

// File: rtl/phy_reset_seq_chk.sv
module phy_reset_seq_chk #(
  parameter int unsigned ASSERT_CYC = 1
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic phy_rst_n_o,
  input logic ready_o,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic fwd_valid_o,
  input logic rsp_err_o
);
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || phy_rst_n_o)    low_run <= '0;
    else if (low_run != '1)    low_run <= low_run + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!ready_o && !phy_rst_n_o && !rsp_err_o)); // R1

  AST_READY_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> phy_rst_n_o); // R3

  AST_MIN_LOW_TIME: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_rst_n_o) |-> (low_run >= ASSERT_CYC)); // R4

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!phy_rst_n_o && !ready_o)); // R6

  AST_NO_FWD_UNREADY: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> !fwd_valid_o); // R7

  AST_EARLY_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && req_valid_i) |-> req_ready_o); // R7

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rsp_err_o |-> $past(req_valid_i && !ready_o)); // R7

  AST_READY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (ready_o && $past(ready_o)) |-> !rsp_err_o); // R8
endmodule

bind phy_reset_seq phy_reset_seq_chk #(.ASSERT_CYC(ASSERT_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .phy_rst_n_o (phy_rst_n_o),
  .ready_o     (ready_o),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .fwd_valid_o (fwd_valid_o),
  .rsp_err_o   (rsp_err_o)
);

// File: tb/sim_phy_reset_seq.sv
module sim_phy_reset_seq;
  localparam int unsigned CMD_W = 16;
  localparam int A  = 4;
  localparam int WC = 30;
  localparam int WW = 12;

  typedef struct packed {
    logic             is_err;
    logic [CMD_W-1:0] cmd;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             phy_rst_n_o, ready_o;
  logic             req_valid_i = 1'b0;
  logic [CMD_W-1:0] req_cmd_i = '0;
  logic             req_ready_o, fwd_valid_o, fwd_ready_i = 1'b1, rsp_err_o;
  logic [CMD_W-1:0] fwd_cmd_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  phy_reset_seq #(
    .CLK_HZ(1_000_000), .ASSERT_US(A), .COLD_US(WC), .WARM_US(WW), .CMD_W(CMD_W)
  ) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .phy_rst_n_o(phy_rst_n_o),
    .ready_o(ready_o), .req_valid_i(req_valid_i), .req_cmd_i(req_cmd_i),
    .req_ready_o(req_ready_o), .fwd_valid_o(fwd_valid_o), .fwd_cmd_o(fwd_cmd_o),
    .fwd_ready_i(fwd_ready_i), .rsp_err_o(rsp_err_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Trigger (start pulse or reset release) then follow the pin and ready edges.
  task automatic run_seq(input bit use_start, input int w, input string tp, input string tr);
    if (use_start) start_i = 1'b1; else rst = 1'b0;
    for (int n = 1; n <= A + w + 2; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk(phy_rst_n_o == (n > A), tp, phy_rst_n_o, (n > A));
      chk(ready_o == (n > A + w), tr, ready_o, (n > A + w));
    end
  endtask

  // Driver: called at a falling edge; pushes the expected outcome first.
  task automatic send(input logic [CMD_W-1:0] cmd, input bit expect_err);
    bit acc;
    item_t it;
    it.is_err = expect_err;
    it.cmd    = expect_err ? '0 : cmd;
    sb.push_back(it);
    req_valid_i = 1'b1;
    req_cmd_i   = cmd;
    acc = 1'b0;
    while (!acc) begin
      #9 acc = req_ready_o;
      @(negedge clk);
    end
    req_valid_i = 1'b0;
  endtask

  // Monitor: samples 5 ns before each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #15;
      if (!rst) begin
        if (fwd_valid_o && fwd_ready_i) begin
          if (sb.size() == 0) chk(0, "R8", fwd_cmd_o, -1);
          else begin
            item_t e;
            e = sb.pop_front();
            chk(!e.is_err && e.cmd == fwd_cmd_o, e.is_err ? "R7" : "R8", fwd_cmd_o, e.cmd);
          end
        end
        if (rsp_err_o) begin
          if (sb.size() == 0) chk(0, "R7", 1, 0);
          else begin
            item_t e;
            e = sb.pop_front();
            chk(e.is_err, "R7", 1, e.is_err);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(phy_rst_n_o == 1'b0, "R1", phy_rst_n_o, 0);
    chk(ready_o == 1'b0, "R1", ready_o, 0);
    chk(fwd_valid_o == 1'b0 && rsp_err_o == 1'b0, "R1", {fwd_valid_o, rsp_err_o}, 0);

    // R2, R3: power-on with cold wait
    run_seq(1'b0, WC, "R2", "R3");
    // R4, R5: warm start uses the short wait
    run_seq(1'b1, WW, "R4", "R5");
    // R6: restart in the middle of the boot wait
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (A + 3) @(negedge clk);
    chk(phy_rst_n_o && !ready_o, "R6", {phy_rst_n_o, ready_o}, 2);
    run_seq(1'b1, WW, "R6", "R6");
    // R6: restart from ready
    run_seq(1'b1, WW, "R6", "R6");

    // R7: early requests back to back, never stalled
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    send(16'h1111, 1'b1);
    send(16'h2222, 1'b1);
    send(16'h3333, 1'b1);
    while (!ready_o) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R7", sb.size(), 0);

    // R8: forwarding while ready
    send(16'hA5A5, 1'b0);
    send(16'h0F0F, 1'b0);
    fwd_ready_i = 1'b0;
    req_valid_i = 1'b1;
    req_cmd_i   = 16'hBEEF;
    #5;
    chk(req_ready_o == 1'b0, "R8", req_ready_o, 0);
    chk(fwd_valid_o == 1'b1 && fwd_cmd_o == 16'hBEEF, "R8", fwd_cmd_o, 16'hBEEF);
    @(negedge clk);
    req_valid_i = 1'b0;
    fwd_ready_i = 1'b1;
    send(16'hBEEF, 1'b0);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R8", sb.size(), 0);

    // R1, R3: a new power-on reset brings back the cold wait
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(phy_rst_n_o == 1'b0 && ready_o == 1'b0, "R1", {phy_rst_n_o, ready_o}, 0);
    run_seq(1'b0, WC, "R2", "R3");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule